// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block turns a stream of read and write requests into SDRAM command pin activity. Each request names a bank, a row, a column and a direction, and arrives on a valid/ready port. The sequencer keeps one row open in each bank and does not close a bank after each access. Each request therefore takes one of three paths. A row hit goes straight to a column command. A request to a closed bank first gets an activate. A request to a different row in an open bank gets a precharge, then an activate, then the column command.

The sequencer enforces two delays, both set by parameters in clock cycles. The first runs from an activate to the column command of the same bank. The second runs from a precharge to the next activate of that bank. At most one command leaves per cycle, and requests are served strictly in arrival order. Row hits to several open banks, whether to the same bank or alternating between banks, flow at one column command per clock. The host sees ready only in the cycle its request's column command is decided. That command appears on the registered pins one clock later.

Top module: `sdram_row_sequencer`

## Requirements
- R1: While reset is held, CS#, RAS#, CAS# and WE# are all high and the bank and address pins are zero, and every bank is marked closed. In idle cycles after reset the pins carry NOP: CS# low and RAS#, CAS#, WE# high.
- R2: A column command drives CS# low, RAS# high and CAS# low, with WE# high for a read and low for a write. The bank pins carry the request's bank. The low COL_BITS of the address carry the column and the upper address bits are zero. It appears on the pins in the cycle after the cycle in which ready is high.
- R3: An activate drives CS# low, RAS# low, CAS# high and WE# high, with the request's bank on the bank pins and its row on the address pins.
- R4: A precharge drives CS# low, RAS# low, CAS# high and WE# low, with the request's bank on the bank pins and zero on the address pins.
- R5: A request to the row already open in its bank, with the activate delay satisfied, gets ready in the same cycle it becomes valid. Its column command is the next pin command, with no activate or precharge before it.
- R6: A request to a closed bank causes an activate on the pins in the cycle after the request appears. Its column command follows exactly TRCD cycles after that activate.
- R7: A request to another row in an open bank causes a precharge in the cycle after the request appears. The activate of the new row follows TRP cycles after the precharge, and the column command follows TRCD cycles after that activate.
- R8: Several banks stay open at the same time. Back-to-back row hits that alternate between open banks get ready and column commands on consecutive cycles.
- R9: At most one command is driven per cycle. Ready stays low while an activate or precharge for the head request is pending, and rises first in the cycle its column command is decided.
- R10: Reset forgets every open row, so the first request after reset to a previously open row gets an activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Host request present; held with fields stable until ready |
| reqReady | output | 1 | Request accepted this cycle (its column command is issued) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_BITS (2) | Target bank |
| reqRow | input | ROW_BITS (13) | Target row |
| reqCol | input | COL_BITS (10) | Starting column |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_BITS (2) | Bank address |
| sdAddr | output | ADDR_BITS (13) | Row or column address |

## Verification
Take a request that is first presented in cycle s. A row hit raises ready in cycle s and drives its column command in cycle s+1. A closed bank drives its activate in cycle s+1 and its column command in cycle s+1+TRCD. A row miss drives its precharge in cycle s+1, its activate in cycle s+1+TRP and its column command in cycle s+1+TRP+TRCD. The bench drives inputs just after the falling edge and logs the decoded pins at each falling edge against the cycle index. Each scenario task compares the logged command kind, bank and address at exactly those indices, and checks the cycle in which ready was first seen.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // Strobes from the control to the datapath: at most one is high per cycle.
  typedef struct packed {
    logic doAct;
    logic doPre;
    logic doCol;
  } seqStrobe_t;

  // Lookup results for the bank addressed by the head request.
  typedef struct packed {
    logic bankOpen;
    logic rowHit;
    logic rcdDone;
    logic rpDone;
  } bankStatus_t;

  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_WAIT,
    DEC_ACT,
    DEC_PRE,
    DEC_COL
  } seqDecision_e;

  // Pin patterns {RAS#, CAS#, WE#} with CS# low.
  localparam logic [2:0] PIN_NOP   = 3'b111;
  localparam logic [2:0] PIN_ACT   = 3'b011;
  localparam logic [2:0] PIN_PRE   = 3'b010;
  localparam logic [2:0] PIN_READ  = 3'b101;
  localparam logic [2:0] PIN_WRITE = 3'b100;

endpackage

// File: rtl/sdr_seq_bank_timer.sv
module sdr_seq_bank_timer #(
  parameter int TIMER_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [TIMER_W-1:0] loadVal,
  output logic               done
);

  logic [TIMER_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign done = (count == '0);

  AST_TIMER_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (!load && count != '0) |=> (count == $past(count) - 1'b1)); // R6

endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  bankStatus_t status,
  output seqStrobe_t  strobe,
  output logic        reqReady
);

  seqDecision_e decision;

  always_comb begin
    decision = DEC_IDLE;
    if (reqValid) begin
      if (status.bankOpen && status.rowHit) begin
        decision = status.rcdDone ? DEC_COL : DEC_WAIT;
      end else if (status.bankOpen) begin
        decision = DEC_PRE;
      end else begin
        decision = status.rpDone ? DEC_ACT : DEC_WAIT;
      end
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.doAct = (decision == DEC_ACT);
    strobe.doPre = (decision == DEC_PRE);
    strobe.doCol = (decision == DEC_COL);
  end

  assign reqReady = strobe.doCol;

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.doAct, strobe.doPre, strobe.doCol}) <= 1); // R9

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (strobe == '0)); // R9

endmodule

// File: rtl/sdr_seq_datapath.sv
module sdr_seq_datapath
  import sdr_seq_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 13,
  parameter int COL_BITS  = 10,
  parameter int ADDR_BITS = 13,
  parameter int TRCD      = 2,
  parameter int TRP       = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic                 reqWrite,
  input  logic [BANK_BITS-1:0] reqBank,
  input  logic [ROW_BITS-1:0]  reqRow,
  input  logic [COL_BITS-1:0]  reqCol,
  output bankStatus_t          status,
  output logic                 sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [BANK_BITS-1:0] sdBa,
  output logic [ADDR_BITS-1:0] sdAddr
);

  localparam int NUM_BANKS = 1 << BANK_BITS;
  localparam int MAX_WAIT  = (TRCD > TRP) ? TRCD : TRP;
  localparam int TIMER_W   = $clog2(MAX_WAIT + 1);
  localparam logic [TIMER_W-1:0] RCD_LOAD = TIMER_W'(TRCD - 1);
  localparam logic [TIMER_W-1:0] RP_LOAD  = TIMER_W'(TRP - 1);

  logic [NUM_BANKS-1:0] bankValid;
  logic [ROW_BITS-1:0]  bankRow [NUM_BANKS];
  logic [NUM_BANKS-1:0] rcdDone;
  logic [NUM_BANKS-1:0] rpDone;

  // Per-bank open-row table and delay timers.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic selected;
    assign selected = (reqBank == BANK_BITS'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankValid[b] <= 1'b0;
        bankRow[b]   <= '0;
      end else if (selected && strobe.doAct) begin
        bankValid[b] <= 1'b1;
        bankRow[b]   <= reqRow;
      end else if (selected && strobe.doPre) begin
        bankValid[b] <= 1'b0;
      end
    end

    sdr_seq_bank_timer #(.TIMER_W(TIMER_W)) u_rcd (
      .clk    (clk),
      .rstN   (rstN),
      .load   (selected && strobe.doAct),
      .loadVal(RCD_LOAD),
      .done   (rcdDone[b])
    );

    sdr_seq_bank_timer #(.TIMER_W(TIMER_W)) u_rp (
      .clk    (clk),
      .rstN   (rstN),
      .load   (selected && strobe.doPre),
      .loadVal(RP_LOAD),
      .done   (rpDone[b])
    );
  end

  always_comb begin
    status          = '0;
    status.bankOpen = bankValid[reqBank];
    status.rowHit   = (bankRow[reqBank] == reqRow);
    status.rcdDone  = rcdDone[reqBank];
    status.rpDone   = rpDone[reqBank];
  end

  // Registered command pins.
  logic [2:0] pinNext;
  logic [ADDR_BITS-1:0] addrNext;

  always_comb begin
    pinNext  = PIN_NOP;
    addrNext = '0;
    if (strobe.doAct) begin
      pinNext  = PIN_ACT;
      addrNext = ADDR_BITS'(reqRow);
    end else if (strobe.doPre) begin
      pinNext  = PIN_PRE;
    end else if (strobe.doCol) begin
      pinNext  = reqWrite ? PIN_WRITE : PIN_READ;
      addrNext = ADDR_BITS'(reqCol);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCsN  <= 1'b1;
      sdRasN <= 1'b1;
      sdCasN <= 1'b1;
      sdWeN  <= 1'b1;
      sdBa   <= '0;
      sdAddr <= '0;
    end else begin
      sdCsN                   <= 1'b0;
      {sdRasN, sdCasN, sdWeN} <= pinNext;
      sdBa                    <= (strobe == '0) ? '0 : reqBank;
      sdAddr                  <= addrNext;
    end
  end

  AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAct |-> (!bankValid[reqBank] && rpDone[reqBank])); // R6

  AST_PRE_ONLY_MISS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPre |-> (bankValid[reqBank] && bankRow[reqBank] != reqRow)); // R7

  AST_COL_ONLY_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCol |-> (bankValid[reqBank] && bankRow[reqBank] == reqRow
                      && rcdDone[reqBank])); // R5

  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAct |=> bankValid[$past(reqBank)]); // R8

endmodule

// File: rtl/sdram_row_sequencer.sv
module sdram_row_sequencer
  import sdr_seq_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 13,
  parameter int COL_BITS  = 10,
  parameter int TRCD      = 2,
  parameter int TRP       = 2,
  localparam int ADDR_BITS = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [BANK_BITS-1:0] reqBank,
  input  logic [ROW_BITS-1:0]  reqRow,
  input  logic [COL_BITS-1:0]  reqCol,
  output logic                 sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [BANK_BITS-1:0] sdBa,
  output logic [ADDR_BITS-1:0] sdAddr
);

  seqStrobe_t  strobe;
  bankStatus_t status;

  sdr_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .status  (status),
    .strobe  (strobe),
    .reqReady(reqReady)
  );

  sdr_seq_datapath #(
    .BANK_BITS(BANK_BITS),
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .ADDR_BITS(ADDR_BITS),
    .TRCD     (TRCD),
    .TRP      (TRP)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqWrite(reqWrite),
    .reqBank (reqBank),
    .reqRow  (reqRow),
    .reqCol  (reqCol),
    .status  (status),
    .sdCsN   (sdCsN),
    .sdRasN  (sdRasN),
    .sdCasN  (sdCasN),
    .sdWeN   (sdWeN),
    .sdBa    (sdBa),
    .sdAddr  (sdAddr)
  );

  AST_READY_THEN_COLUMN: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> (!sdCsN && sdRasN && !sdCasN && sdWeN == !$past(reqWrite))); // R2

  AST_COLUMN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN && sdRasN && !sdCasN) |-> $past(reqReady)); // R9

  AST_HOST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqBank) && $stable(reqRow))); // R9

endmodule

// File: tb/sdram_row_sequencer_bench.sv
module sdram_row_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_BITS  = 2;
  localparam int ROW_BITS   = 13;
  localparam int COL_BITS   = 10;
  localparam int ADDR_BITS  = 13;
  localparam int TRCD       = 2;
  localparam int TRP        = 2;
  localparam int LOG_DEPTH  = 1024;

  localparam int K_DESEL = 0, K_NOP = 1, K_ACT = 2, K_PRE = 3, K_RD = 4, K_WR = 5, K_BAD = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [BANK_BITS-1:0] reqBank = '0;
  logic [ROW_BITS-1:0]  reqRow = '0;
  logic [COL_BITS-1:0]  reqCol = '0;
  logic sdCsN, sdRasN, sdCasN, sdWeN;
  logic [BANK_BITS-1:0] sdBa;
  logic [ADDR_BITS-1:0] sdAddr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int logKind [LOG_DEPTH];
  int logBa   [LOG_DEPTH];
  int logAddr [LOG_DEPTH];

  sdram_row_sequencer #(
    .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
    .TRCD(TRCD), .TRP(TRP)
  ) u_sdram_row_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int decodeKind(logic cs, logic ras, logic cas, logic we);
    if (cs) return K_DESEL;
    case ({ras, cas, we})
      3'b111:  return K_NOP;
      3'b011:  return K_ACT;
      3'b010:  return K_PRE;
      3'b101:  return K_RD;
      3'b100:  return K_WR;
      default: return K_BAD;
    endcase
  endfunction

  always @(negedge clk) begin
    if (cyc < LOG_DEPTH) begin
      logKind[cyc] = decodeKind(sdCsN, sdRasN, sdCasN, sdWeN);
      logBa[cyc]   = int'(sdBa);
      logAddr[cyc] = int'(sdAddr);
    end
  end

  task automatic check(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic checkCmd(string tag, int idx, int kind, int ba, int addr);
    check({tag, " kind"}, logKind[idx], kind);
    check({tag, " bank"}, logBa[idx], ba);
    check({tag, " addr"}, logAddr[idx], addr);
  endtask

  // Present one request at the current falling edge; return the cycle index
  // it first appeared and the index in which ready was seen.
  task automatic sendReq(input logic wr, input int bank, input int row, input int col,
                         output int startIdx, output int readyIdx);
    int waited;
    reqWrite = wr;
    reqBank  = BANK_BITS'(bank);
    reqRow   = ROW_BITS'(row);
    reqCol   = COL_BITS'(col);
    reqValid = 1'b1;
    startIdx = cyc;
    #1;
    waited = 0;
    while (!reqReady && waited < 60) begin
      @(negedge clk);
      #1;
      waited++;
    end
    if (!reqReady) check("R9 ready never rose", 0, 1);
    readyIdx = cyc;
    @(negedge clk);
    reqValid = 1'b0;
    #2;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset cs", int'(sdCsN), 1);
    check("R1 reset ras/cas/we", int'({sdRasN, sdCasN, sdWeN}), 7);
    check("R1 reset bank", int'(sdBa), 0);
    check("R1 reset addr", int'(sdAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #2;
    check("R1 idle nop", logKind[cyc], K_NOP);
    check("R1 idle no ready", int'(reqReady), 0);
  endtask

  task automatic testClosedBank();
    int s, r;
    sendReq(1'b0, 0, 5, 7, s, r);
    checkCmd("R3 R6 activate", s + 1, K_ACT, 0, 5);
    for (int i = s + 2; i < s + 1 + TRCD; i++) check("R6 gap nop", logKind[i], K_NOP);
    check("R6 R9 ready cycle", r, s + TRCD);
    checkCmd("R2 R6 read column", s + 1 + TRCD, K_RD, 0, 7);
  endtask

  task automatic testRowHit();
    int s, r;
    sendReq(1'b1, 0, 5, 9, s, r);
    check("R5 hit ready same cycle", r, s);
    checkCmd("R2 R5 write column", s + 1, K_WR, 0, 9);
  endtask

  task automatic testRowMiss();
    int s, r;
    sendReq(1'b0, 0, 6, 1023, s, r);
    checkCmd("R4 R7 precharge", s + 1, K_PRE, 0, 0);
    check("R7 wait nop", logKind[s + 2], K_NOP);
    checkCmd("R7 activate after tRP", s + 1 + TRP, K_ACT, 0, 6);
    check("R7 R9 ready cycle", r, s + TRP + TRCD);
    checkCmd("R2 R7 column after tRCD", s + 1 + TRP + TRCD, K_RD, 0, 1023);
  endtask

  task automatic testInterleave();
    int s, r;
    int rdy [4];
    sendReq(1'b0, 1, 3, 1, s, r);
    checkCmd("R3 activate bank1", s + 1, K_ACT, 1, 3);
    sendReq(1'b1, 2, 8191, 2, s, r);
    checkCmd("R3 activate bank2 full row", s + 1, K_ACT, 2, 8191);
    checkCmd("R2 write bank2", s + 1 + TRCD, K_WR, 2, 2);
    for (int i = 0; i < 4; i++) begin
      sendReq(i[0], (i % 2 == 0) ? 1 : 2, (i % 2 == 0) ? 3 : 8191, 10 + i, s, r);
      rdy[i] = r;
      check("R8 alternating hit ready", r, s);
      checkCmd("R8 alternating column", r + 1, i[0] ? K_WR : K_RD,
               (i % 2 == 0) ? 1 : 2, 10 + i);
    end
    for (int i = 1; i < 4; i++) check("R8 back to back", rdy[i], rdy[i - 1] + 1);
    sendReq(1'b0, 0, 6, 4, s, r);
    check("R8 bank0 still open", r, s);
    checkCmd("R8 bank0 column", s + 1, K_RD, 0, 4);
  endtask

  task automatic testResetForgets();
    int s, r;
    doReset();
    sendReq(1'b0, 0, 6, 3, s, r);
    checkCmd("R10 activate after reset", s + 1, K_ACT, 0, 6);
    check("R10 ready after activate", r, s + TRCD);
    checkCmd("R10 column", s + 1 + TRCD, K_RD, 0, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testClosedBank();
    testRowHit();
    testRowMiss();
    testInterleave();
    testResetForgets();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule